// File: doc/BRIEF.md
# Dual-Read Program Register File with Null Identifier

This block holds the general-purpose program registers of a small 32-bit processor: eight words, read through two independent combinational ports and written through a single port that updates on the rising clock edge. Each port addresses a register with a 4-bit identifier. Codes 0 to 7 select a register. Every other code, and in particular the all-ones code, means "no register".

A read port given a code that names no register returns zero. A write given such a code changes nothing. Decode stages can therefore route "unused operand" and "no destination" through the same wires as real register numbers, with no separate enable. A third read-only port indexes the registers directly by a 3-bit number so that a bench can inspect the whole file. A synchronous reset clears every register.

Top module: `regbank_dual_rd`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes zero; after reset, all eight registers read 0x00000000 on every read port.
- R2: With `wr_id` in 0..7, the value on `wr_data` is stored into that register at the rising clock edge and reads back from the next cycle on. Register codes are eax=0, ecx=1, edx=2, ebx=3, esp=4, ebp=5, esi=6, edi=7.
- R3: Reads are combinational: `rd_a_data` and `rd_b_data` follow changes of `rd_a_id` and `rd_b_id` within the same cycle, with no clock edge in between.
- R4: A read with identifier 0xF returns 0x00000000, whatever the registers hold.
- R5: A write with `wr_id` equal to 0xF changes no register.
- R6: Identifiers 8 to 14 behave like 0xF: reading one returns zero, and writing one changes no register.
- R7: When a read and a write name the same register in one cycle, the read returns the old contents until the edge and the new contents after it.
- R8: Both read ports and the write port operate independently in the same cycle; two reads of one identifier return equal data.
- R9: `dbg_data` returns the contents of the register numbered by the 3-bit `dbg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rd_a_id | input | 4 | Identifier for read port A |
| rd_a_data | output | 32 | Data of read port A, zero for a non-register identifier |
| rd_b_id | input | 4 | Identifier for read port B |
| rd_b_data | output | 32 | Data of read port B, zero for a non-register identifier |
| wr_id | input | 4 | Write identifier; a non-register code suppresses the write |
| wr_data | input | 32 | Data to be written |
| dbg_idx | input | 3 | Register number for the inspection port |
| dbg_data | output | 32 | Contents of the register chosen by `dbg_idx` |

## Verification
The bench goes after the out-of-range identifiers 8 to 14 as well as 0xF. A decoder that only compares against all-ones would alias those codes onto registers 0 to 6: reads would return live data, and writes would overwrite a real register, which the full scan through the inspection port exposes. A read of the register being written in the same cycle must still show the old word. A file with write-through forwarding would show the new word one cycle early. Reads are also probed twice inside one clock phase, so that a registered read path would be caught returning stale data.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   // Number of index bits needed to address n entries (at least 1).
   function automatic int unsigned idx_bits(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction

   // True when n is an exact power of two.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/regbank_id_dec.sv
module regbank_id_dec
   import regbank_pkg::*;
#(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned IDX_W    = 3
) (
   input  logic [ID_W-1:0]  id,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   assign idx = id[IDX_W-1:0];

   generate
      if (is_pow2(NUM_REGS)) begin : g_pow2
         // Register count fills the low bits exactly: any upper bit set is a miss.
         assign hit = ~|id[ID_W-1:IDX_W];
      end else begin : g_cmp
         // Arbitrary count: magnitude compare against the register count.
         assign hit = (32'(id) < 32'(NUM_REGS));
      end
   endgenerate

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             wr_hit,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_word
         logic sel;
         assign sel = wr_hit && (32'(wr_idx) == g);
         always_ff @(posedge clk) begin
            if (rst) regs[g] <= '0;
            else if (sel) regs[g] <= wr_data;
         end
      end
   endgenerate

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> regs[$past(wr_idx)] == $past(wr_data));

   // R5 R6
   miss_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_hit |=> regs == $past(regs));

endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port #(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned IDX_W    = 3
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [ID_W-1:0]                 id,
   output logic [DATA_W-1:0]               data
);

   logic             hit;
   logic [IDX_W-1:0] idx;

   regbank_id_dec #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_dec (
      .id  (id),
      .hit (hit),
      .idx (idx)
   );

   always_comb begin
      data = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (hit && (32'(idx) == k)) data = regs[k];
   end

endmodule

// File: rtl/regbank_dual_rd.sv
module regbank_dual_rd
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned IDX_W    = idx_bits(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   rd_a_id,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ID_W-1:0]   rd_b_id,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  dbg_idx,
   output logic [DATA_W-1:0] dbg_data
);

   localparam int unsigned  NUM_RD  = 2;
   localparam logic [ID_W-1:0] NULL_ID = '1;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("regbank_dual_rd: DATA_W must be at least 1");
      end
      if (NUM_REGS < 2) begin : g_bad_count
         $error("regbank_dual_rd: NUM_REGS must be at least 2");
      end
      if (ID_W > 16 || (1 << ID_W) <= NUM_REGS) begin : g_bad_id
         $error("regbank_dual_rd: ID_W must leave at least one code that names no register");
      end
      if (IDX_W != idx_bits(NUM_REGS)) begin : g_bad_idx
         $error("regbank_dual_rd: IDX_W must match NUM_REGS");
      end
   endgenerate

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic                            wr_hit;
   logic [IDX_W-1:0]                wr_idx;

   regbank_id_dec #(.ID_W(ID_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_wr_dec (
      .id  (wr_id),
      .hit (wr_hit),
      .idx (wr_idx)
   );

   regbank_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_store (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .regs    (regs)
   );

   logic [NUM_RD-1:0][ID_W-1:0]   rd_ids;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_vals;

   assign rd_ids[0] = rd_a_id;
   assign rd_ids[1] = rd_b_id;

   genvar p;
   generate
      for (p = 0; p < NUM_RD; p++) begin : g_rd
         regbank_rd_port #(
            .ID_W(ID_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
         ) i_port (
            .regs (regs),
            .id   (rd_ids[p]),
            .data (rd_vals[p])
         );
      end
   endgenerate

   assign rd_a_data = rd_vals[0];
   assign rd_b_data = rd_vals[1];

   always_comb begin
      dbg_data = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (32'(dbg_idx) == k) dbg_data = regs[k];
   end

   // R4
   null_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id == NULL_ID) |-> (rd_a_data == '0));

   // R8
   same_id_same_data_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data));

   // R9
   dbg_matches_port_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(rd_b_id) == 32'(dbg_idx)) |-> (rd_b_data == dbg_data));

endmodule

// File: tb/test_regbank_dual_rd.sv
module test_regbank_dual_rd;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  rd_a_id = 4'hF, rd_b_id = 4'hF, wr_id = 4'hF;
   logic [31:0] wr_data = '0;
   logic [2:0]  dbg_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, dbg_data;

   always #5 clk = ~clk;

   regbank_dual_rd i_regbank_dual_rd (
      .clk(clk), .rst(rst),
      .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
      .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
      .wr_id(wr_id), .wr_data(wr_data),
      .dbg_idx(dbg_idx), .dbg_data(dbg_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] mdl [8];

   // Scoreboard queues: port (0=A, 1=B, 2=dbg), expected value, requirement tag.
   int          q_port [$];
   logic [31:0] q_exp  [$];
   string       q_tag  [$];

   function automatic logic [31:0] expect_rd(input logic [3:0] id);
      return (id < 4'd8) ? mdl[id[2:0]] : 32'h0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: one cycle of traffic; expectations come from the model before the edge.
   task automatic op(input logic [3:0] ra, input logic [3:0] rb,
                     input logic [3:0] wid, input logic [31:0] wd,
                     input logic [2:0] di, input string tag);
      @(negedge clk);
      rd_a_id = ra; rd_b_id = rb; wr_id = wid; wr_data = wd; dbg_idx = di;
      q_port.push_back(0); q_exp.push_back(expect_rd(ra)); q_tag.push_back(tag);
      q_port.push_back(1); q_exp.push_back(expect_rd(rb)); q_tag.push_back(tag);
      q_port.push_back(2); q_exp.push_back(mdl[di]);       q_tag.push_back(tag);
      if (wid < 4'd8) mdl[wid[2:0]] = wd;
   endtask

   // Monitor: compares outputs mid-phase, well away from the rising edge.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q_port.size() > 0) begin
            int          pt;
            logic [31:0] ex;
            string       tg;
            pt = q_port.pop_front(); ex = q_exp.pop_front(); tg = q_tag.pop_front();
            case (pt)
               0:       check({tg, " port A"}, rd_a_data, ex);
               1:       check({tg, " port B"}, rd_b_data, ex);
               default: check({tg, " dbg"},    dbg_data,  ex);
            endcase
         end
      end
   end

   task automatic scan_all(input string tag);
      for (int i = 0; i < 8; i++)
         op(4'(i), 4'(7 - i), 4'hF, 32'h0, 3'(i), tag);
   endtask

   function automatic logic [31:0] pat(input int i);
      return 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'h0000_1234;
   endfunction

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1: reset state on all ports
      scan_all("R1 reset");

      // R2: write each register, then read it back
      for (int i = 0; i < 8; i++) op(4'hF, 4'hF, 4'(i), pat(i), 3'(i), "R2 write");
      for (int i = 0; i < 8; i++) op(4'(i), 4'((i + 3) % 8), 4'hF, 32'h0, 3'(i), "R2 readback");

      // R4: null read returns zero while registers are live
      op(4'hF, 4'hF, 4'hF, 32'h0, 3'd5, "R4 null read");

      // R5: write with null id, then scan to confirm nothing moved
      op(4'hF, 4'h2, 4'hF, 32'hDEAD_BEEF, 3'd0, "R5 null write");
      scan_all("R5 scan");

      // R6: out-of-range ids read zero and do not write
      for (int i = 8; i < 15; i++) op(4'(i), 4'(i), 4'(i), 32'hBAD0_0000 | 32'(i), 3'(i - 8), "R6 range");
      scan_all("R6 scan");

      // R7: same-cycle read and write of one register
      op(4'd3, 4'd3, 4'd3, 32'h1357_9BDF, 3'd3, "R7 old value");
      op(4'd3, 4'd6, 4'hF, 32'h0, 3'd3, "R7 new value");

      // R8: two reads and a write together, and equal ids
      op(4'd1, 4'd2, 4'd5, 32'h0F0F_5555, 3'd5, "R8 parallel");
      op(4'd5, 4'd5, 4'd4, 32'h7777_0001, 3'd4, "R8 same id");
      op(4'd4, 4'd5, 4'hF, 32'h0, 3'd4, "R8 after");

      // R9: inspection port across all indices
      scan_all("R9 dbg");

      // R3: combinational read inside one low phase
      @(negedge clk);
      wr_id = 4'hF;
      rd_a_id = 4'd2; #1 check("R3 comb A id2", rd_a_data, mdl[2]);
      rd_a_id = 4'd6; #1 check("R3 comb A id6", rd_a_data, mdl[6]);
      rd_b_id = 4'd0; #1 check("R3 comb B id0", rd_b_data, mdl[0]);

      // R1: reset in the middle of operation clears everything
      @(negedge clk); rst = 1'b1; wr_id = 4'd1; wr_data = 32'hFFFF_FFFF;
      @(negedge clk); rst = 1'b0; wr_id = 4'hF;
      for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
      scan_all("R1 mid-run reset");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule